// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block sits on the controller side of a two-wire serial bus. It frees a bus that a target device holds stuck after an interrupted transfer, a power drop or a reset. When asked to, it clocks SCL with SDA left floating. After every high phase of SCL it looks at SDA. As soon as SDA reads high, the target has let go. The block then issues a start condition, pulling SDA low while SCL stays high, and releases both lines. SCL rising before SDA is released leaves the bus idle again.

The clocking stops after a bounded number of pulses, nine by default. If SDA never comes back high, the sequence ends with a failure flag and both lines floating. Both lines are driven through open-drain enables. The SDA input passes through two flops before it is looked at. The low phase, high phase and start-hold lengths are parameters counted in system-clock cycles. The defaults suit a 50 MHz system clock at 100 kHz bus timing (4.7 us low, 4.0 us high, 4.0 us start hold).

Top module: `bus_unstick`

## Requirements
- R1: While reset is asserted and after it is released, `scl_pull_o`, `sda_pull_o`, `busy_o`, `done_o` and `fail_o` are all 0. A pull output of 1 means the line is driven low, and 0 means it is released.
- R2: A request in idle starts the clocking. Each pulse holds `scl_pull_o` at 1 for exactly LOW_CYC cycles and then at 0 for exactly HIGH_CYC cycles.
- R3: No more than MAX_PULSES (default 9) low-then-high SCL pulses are produced per request.
- R4: SDA is synchronised by two flops and judged in the last cycle of each high phase. If SDA has read high by the time the high phase of pulse k ends, no further SCL pulse follows, so k pulses are produced in total.
- R5: After SDA is seen high, `sda_pull_o` is 1 for exactly HOLD_CYC cycles while `scl_pull_o` stays 0. Both lines are then released and `done_o` is raised with `fail_o` at 0. `sda_pull_o` is never 1 while `scl_pull_o` is 1.
- R6: If SDA is still low at the end of the last allowed high phase, `done_o` and `fail_o` are raised together, both lines are released, and `sda_pull_o` is never driven during that sequence.
- R7: `done_o` is high for one clock cycle per sequence, and `fail_o` is only ever high together with `done_o`.
- R8: `busy_o` is 1 while a sequence runs. A request that arrives while busy has no effect: it neither changes the pulse count nor queues a second sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Start a recovery sequence (taken only while idle) |
| sda_i | input | 1 | Level read back from the SDA line |
| scl_pull_o | output | 1 | 1 drives SCL low, 0 releases it |
| sda_pull_o | output | 1 | 1 drives SDA low, 0 releases it |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse when a sequence ends |
| fail_o | output | 1 | High with done_o when SDA never came free |

## Verification
A phase counter that is off by one shows up at the pull outputs within a single pulse. The low or high run then differs from LOW_CYC or HIGH_CYC, or the start hold differs from HOLD_CYC. A wrong pulse counter or a wrong SDA decision shows only at the end of a sequence: the number of SCL pulses is wrong, a start appears where a failure is expected, or the reverse. For that reason, releases are placed before the first pulse, in the middle, just before the last pulse and never. A request accepted while busy shows as extra pulses or a second done pulse. Reset mid-sequence must release both lines at the next clock.

// File: rtl/bus_unstick.sv
module bus_unstick #(
  parameter int LOW_CYC    = 235,
  parameter int HIGH_CYC   = 200,
  parameter int HOLD_CYC   = 200,
  parameter int MAX_PULSES = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic sda_i,
  output logic scl_pull_o,
  output logic sda_pull_o,
  output logic busy_o,
  output logic done_o,
  output logic fail_o
);
  localparam int LONG1   = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int LONGEST = (LONG1 > HOLD_CYC) ? LONG1 : HOLD_CYC;
  localparam int CW      = $clog2(LONGEST + 1);
  localparam int PW      = $clog2(MAX_PULSES + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH, S_HOLD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [PW-1:0] pulses;
  logic [1:0]    sync;
  logic          sda_s;
  logic          phase_end;
  int            lim;

  assign sda_s      = sync[1];
  assign scl_pull_o = (st == S_LOW);
  assign sda_pull_o = (st == S_HOLD);
  assign busy_o     = (st != S_IDLE);

  always_comb begin
    case (st)
      S_LOW:   lim = LOW_CYC;
      S_HIGH:  lim = HIGH_CYC;
      default: lim = HOLD_CYC;
    endcase
  end
  assign phase_end = (cnt == CW'(lim - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], sda_i};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      pulses <= '0;
      done_o <= 1'b0;
      fail_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      fail_o <= 1'b0;
      case (st)
        S_IDLE: if (req_i) begin
          st     <= S_LOW;
          cnt    <= '0;
          pulses <= '0;
        end
        S_LOW: if (phase_end) begin
          st     <= S_HIGH;
          cnt    <= '0;
          pulses <= pulses + 1'b1;
        end else cnt <= cnt + 1'b1;
        S_HIGH: if (phase_end) begin
          cnt <= '0;
          if (sda_s) st <= S_HOLD;
          else if (pulses == PW'(MAX_PULSES)) begin
            st     <= S_IDLE;
            done_o <= 1'b1;
            fail_o <= 1'b1;
          end else st <= S_LOW;
        end else cnt <= cnt + 1'b1;
        S_HOLD: if (phase_end) begin
          st     <= S_IDLE;
          done_o <= 1'b1;
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R5
  start_under_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sda_pull_o && scl_pull_o));

  // R5
  start_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> $past(sda_s));

  // R3
  pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull_o) |-> (pulses < PW'(MAX_PULSES)));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  fail_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> done_o);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> (busy_o || done_o));
endmodule

// File: tb/tb_bus_unstick.sv
module tb_bus_unstick;
  localparam int PERIOD = 10;
  localparam int LO = 5, HI = 4, HD = 3, MP = 9;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, slave_rel = 1'b0;
  logic scl_pull, sda_pull, busy, done, fail;
  wire  sda_line = slave_rel & ~sda_pull;
  int   checks = 0, failures = 0;

  always #(PERIOD/2) clk = ~clk;

  bus_unstick #(.LOW_CYC(LO), .HIGH_CYC(HI), .HOLD_CYC(HD), .MAX_PULSES(MP)) dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .sda_i(sda_line),
    .scl_pull_o(scl_pull), .sda_pull_o(sda_pull), .busy_o(busy),
    .done_o(done), .fail_o(fail));

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  // release_after, expected pulses, expected fail
  localparam int NV = 6;
  localparam int VEC [NV][3] = '{
    '{0, 1, 0}, '{3, 4, 0}, '{1, 2, 0}, '{8, 9, 0}, '{9, 9, 1}, '{20, 9, 1}};

  task automatic run_seq(input int k, input int exp_p, input bit exp_f, input bit poke);
    int p = 0, lo_run = 0, hi_run = 0, hold = 0, bad_lo = 0, bad_hi = 0, ovl = 0;
    bit prev_scl = 1'b0, seen_done = 1'b0, got_fail = 1'b0;
    slave_rel = 1'b0;
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
    for (int i = 0; i < 800 && !seen_done; i++) begin
      if (scl_pull) begin
        if (!prev_scl && p > 0 && hi_run != HI) bad_hi++;
        lo_run++;
        if (p >= k) slave_rel = 1'b1;
      end else begin
        if (prev_scl) begin
          if (lo_run != LO) bad_lo++;
          p++; lo_run = 0; hi_run = 0;
        end
        if (busy && !sda_pull) hi_run++;
      end
      if (sda_pull) hold++;
      if (sda_pull && scl_pull) ovl++;
      prev_scl = scl_pull;
      req = (poke && (i == 3 || i == 12)) ? 1'b1 : 1'b0;
      if (done) begin
        seen_done = 1'b1;
        got_fail = fail;
        chk(!scl_pull && !sda_pull, "R5/R6 lines released at done", {scl_pull, sda_pull}, 0);
        chk(!busy, "R8 busy low at done", busy, 0);
      end else if (!busy) begin
        break;
      end
      if (!seen_done) @(negedge clk);
    end
    req = 1'b0;
    chk(seen_done, "R7 done seen", seen_done, 1);
    chk(p == exp_p, exp_f ? "R3 pulse count" : "R4 pulse count", p, exp_p);
    chk(got_fail == exp_f, exp_f ? "R6 fail flag" : "R5 fail flag", got_fail, exp_f);
    chk(hold == (exp_f ? 0 : HD), exp_f ? "R6 no start" : "R5 start hold", hold, exp_f ? 0 : HD);
    chk(bad_lo == 0 && bad_hi == 0, "R2 phase lengths", bad_lo + bad_hi, 0);
    chk(ovl == 0, "R5 start with SCL high", ovl, 0);
    @(negedge clk);
    chk(!done && !fail, "R7 done single cycle", {done, fail}, 0);
    if (poke) begin
      repeat (6) @(negedge clk);
      chk(!busy && !scl_pull, "R8 no queued sequence", busy, 0);
    end
    slave_rel = 1'b0;
  endtask

  initial begin
    #(PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({scl_pull, sda_pull, busy, done, fail} == 5'b0, "R1 state in reset",
        {scl_pull, sda_pull, busy, done, fail}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({scl_pull, sda_pull, busy, done, fail} == 5'b0, "R1 idle after reset",
        {scl_pull, sda_pull, busy, done, fail}, 0);

    for (int v = 0; v < NV; v++)
      run_seq(VEC[v][0], VEC[v][1], VEC[v][2] != 0, 1'b0);

    // R8: requests while busy
    run_seq(4, 5, 1'b0, 1'b1);
    run_seq(30, 9, 1'b1, 1'b1);

    // R1: reset in the middle of a sequence
    slave_rel = 1'b0;
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
    repeat (12) @(negedge clk);
    chk(busy, "R8 busy during sequence", busy, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk({scl_pull, sda_pull, busy, done} == 4'b0, "R1 reset mid sequence",
        {scl_pull, sda_pull, busy, done}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy, "R1 stays idle after reset", busy, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule